// File: doc/BRIEF.md
# Serial Two-Wire Control-Register Bank

This block is a target on an I2C bus that gives a host read and write access to sixteen 8-bit control registers. It runs from a fast system clock. It sees the bus only through the sampled SCL and SDA inputs and one open-drain enable that pulls SDA low. Bus conditions are recovered inside the block: START, STOP, and the rising and falling edges of SCL. SDA is only ever changed in the system-clock cycle after a falling SCL edge has been detected.

A write transfer carries the device address, then a register pointer, then any number of data bytes. A read transfer returns data starting from whatever pointer an earlier transfer left behind. A host usually sets that pointer with a pointer-only write that ends in STOP or in a repeated START. Bit 0 of register 0x0A selects how the pointer moves after each data byte, in both directions. When it is 0 the pointer steps by one. When it is 1 the pointer stays put, so a burst keeps hitting one register.

States: IDLE waits for START. ADDR shifts in the address byte and goes to ADDR_ACK on a match, or to IGNORE otherwise. ADDR_ACK goes to PTR for a write, or to RDATA for a read. PTR goes to PTR_ACK, then to WDATA. WDATA goes to WDATA_ACK and back to WDATA. RDATA goes to RACK. RACK goes to RDATA on a master ACK, or to IGNORE on a NACK. IGNORE holds until the next bus condition. In every state, STOP leads to IDLE and START leads to ADDR.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0), the pointer is 0, and all sixteen registers read 0x00.
- R2: The address byte 0xDC (write) or 0xDD (read) is acknowledged by holding SDA low through the ninth SCL pulse. The device address is bits 7..1 = 7'b1101110, and bit 0 is the read flag.
- R3: Any other address byte is not acknowledged. The block then leaves SDA released and changes no register until the next START.
- R4: In a write transfer, the byte after the address loads the pointer from its low 4 bits; its upper bits are ignored. Each later byte is stored at the pointer, and every such byte is acknowledged.
- R5: While bit 0 of register 0x0A is 0 (the reset value), the pointer steps by one after each data byte and wraps from 0xF to 0x0.
- R6: While bit 0 of register 0x0A is 1, the pointer does not move after a data byte. A byte written to 0x0A itself takes effect from the next byte on.
- R7: In a read transfer, data is sent MSB first, starting at the stored pointer. The pointer then advances after each byte by the rule of R5/R6, and it persists across transfers.
- R8: A master NACK after a read byte ends the transmission. SDA stays released and the pointer stays unchanged until STOP or START.
- R9: A START at any point, including in the middle of a byte, restarts the address phase without storing the partial byte. A STOP returns the block to idle.
- R10: sda_oe changes only in the cycle after a detected falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level as seen on the wire |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it to the pull-up |

## Verification
A corrupted pointer is visible on the very next read byte: the value returned comes from the wrong register. A bad step rule shows up within one burst, because each byte of a 16-byte sweep carries a distinct value. A wrong state shows at the ninth clock of the same byte, as a missing or spurious acknowledge, or as a driven SDA where the master expects 0xFF after a NACK. Writes that were dropped or landed in the wrong place are exposed by the full register readback that closes each test phase.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
    parameter int             AW        = 4,
    parameter int             DW        = 8,
    parameter logic [AW-1:0]  MODE_ADDR = 'hA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          mode_bit
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (we && waddr == AW'(g))
                q <= wdata;
        end
        assign mem[g] = q;
    end

    assign rdata    = mem[raddr];
    assign mode_bit = mem[MODE_ADDR][0];

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR    = 7'b1101110,
    parameter int               PTR_W       = 4,
    parameter int               DW          = 8,
    parameter logic [PTR_W-1:0] MODE_REG    = 'hA,
    parameter int               SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int CNT_W = $clog2(DW + 1);

    slv_state_e       state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    shreg;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_adv;
    logic             mack;
    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DW-1:0]    rd_data;
    logic             mode_fixed;
    logic             wr_en;
    logic             byte_full;
    logic             last_tx_bit;
    logic             addr_hit;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_regfile #(.AW(PTR_W), .DW(DW), .MODE_ADDR(MODE_REG)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (ptr),
        .wdata    (shreg),
        .raddr    (ptr),
        .rdata    (rd_data),
        .mode_bit (mode_fixed)
    );

    assign byte_full   = (bit_cnt == CNT_W'(DW));
    assign last_tx_bit = (bit_cnt == CNT_W'(DW - 1));
    assign addr_hit    = (shreg[DW-1:1] == DEV_ADDR);
    assign ptr_adv     = mode_fixed ? ptr : ptr + 1'b1;
    assign wr_en       = (state == ST_WDATA) && scl_fall && byte_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_full)
                                  state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)
                                  state_nx = shreg[0] ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_full) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && last_tx_bit) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall) state_nx = mack ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_nx = ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath: bit counter, shifter, pointer, master acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            mack    <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[DW-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && byte_full) begin
                        bit_cnt <= '0;
                        if (state == ST_PTR)   ptr <= shreg[PTR_W-1:0];
                        if (state == ST_WDATA) ptr <= ptr_adv;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (shreg[0]) shreg <= rd_data;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (last_tx_bit) begin
                            bit_cnt <= '0;
                            ptr     <= ptr_adv;
                        end else begin
                            shreg   <= {shreg[DW-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall && mack) shreg <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shreg[DW-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
    import i2c_rb_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             wr_en,
    input logic             mode_fixed,
    input logic             scl_fall,
    input logic             mack,
    input slv_state_e       state,
    input logic [PTR_W-1:0] ptr
);

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ptr == '0 && !sda_oe));

    a_r3_ignore_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=>
            (state == ST_IGNORE || state == ST_IDLE || state == ST_ADDR));

    a_r5_auto_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_fixed) |=> (ptr == $past(ptr) + 1'b1));

    a_r6_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_fixed) |=> $stable(ptr));

    a_r8_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && !mack) |=> (state == ST_IGNORE));

    a_r10_sda_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall));

endmodule

bind i2c_regbank_slave i2c_rb_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe     (sda_oe),
    .wr_en      (wr_en),
    .mode_fixed (mode_fixed),
    .scl_fall   (scl_fall),
    .mack       (mack),
    .state      (state),
    .ptr        (ptr)
);

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m_low = 1'b0;
    wire  sda_oe;
    wire  sda_bus = !(sda_m_low || sda_oe);

    int checks = 0;
    int errors = 0;

    logic [7:0] mdl [16];
    logic [3:0] mptr = 4'h0;
    logic       mfixed = 1'b0;

    i2c_regbank_slave u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    function automatic logic [3:0] adv(input logic [3:0] p);
        return mfixed ? p : p + 4'h1;
    endfunction

    task automatic mdl_write(input logic [7:0] d);
        logic [3:0] old;
        old = mptr;
        mdl[old] = d;
        mptr = adv(old);
        if (old == 4'hA) mfixed = d[0];
    endtask

    task automatic m_start();
        sda_m_low = 1'b0; wq();
        scl_m = 1'b1;     wq();
        sda_m_low = 1'b1; wq();
        scl_m = 1'b0;     wq();
    endtask

    task automatic m_stop();
        sda_m_low = 1'b1; wq();
        scl_m = 1'b1;     wq();
        sda_m_low = 1'b0; wq(2);
    endtask

    task automatic m_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m_low = !b[i]; wq();
            scl_m = 1'b1;      wq(2);
            scl_m = 1'b0;      wq();
        end
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        m_bits(b, 8);
        sda_m_low = 1'b0; wq();
        scl_m = 1'b1;     wq();
        ack = !sda_bus;   wq();
        scl_m = 1'b0;     wq();
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        sda_m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            d[i] = sda_bus; wq();
            scl_m = 1'b0;
        end
        sda_m_low = give_ack; wq();
        scl_m = 1'b1;         wq(2);
        scl_m = 1'b0;         wq();
        sda_m_low = 1'b0;
    endtask

    task automatic xfer_write(input logic [3:0] p, input int n,
                              input logic [7:0] base, input logic [7:0] step);
        logic ack;
        m_start();
        m_wbyte(8'hDC, ack);     chk("R2 write address ack", ack, 1'b1);
        m_wbyte({~p, p}, ack);   chk("R4 pointer ack", ack, 1'b1);
        mptr = p;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = base + step * 8'(k);
            m_wbyte(d, ack);     chk("R4 data ack", ack, 1'b1);
            mdl_write(d);
        end
        m_stop();
    endtask

    task automatic set_ptr(input logic [3:0] p);
        xfer_write(p, 0, 8'h00, 8'h00);
    endtask

    task automatic xfer_read(input int n, input string tag);
        logic ack;
        logic [7:0] d;
        m_start();
        m_wbyte(8'hDD, ack);     chk("R2 read address ack", ack, 1'b1);
        for (int k = 0; k < n; k++) begin
            m_rbyte(k < n - 1, d);
            chk(tag, d, mdl[mptr]);
            mptr = adv(mptr);
        end
        m_stop();
    endtask

    task automatic verify_all(input string tag);
        set_ptr(4'h0);
        xfer_read(16, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: released bus and zeroed bank, read from the reset pointer
        chk("R1 sda released", sda_oe, 1'b0);
        xfer_read(16, "R1 reset contents");

        // R4 R5: 16-byte burst from pointer 3 wraps through 0xF to 0x0
        xfer_write(4'h3, 16, 8'd12, 8'd38);
        chk("R5 model pointer wrapped", mptr, 4'h3);
        verify_all("R5 burst readback");

        // R3: addresses one bit away from the device address
        for (int b = 1; b < 8; b++) begin
            m_start();
            m_wbyte(8'hDC ^ (8'h01 << b), ack); chk("R3 no address ack", ack, 1'b0);
            m_wbyte(8'h03, ack);                chk("R3 no pointer ack", ack, 1'b0);
            m_wbyte(8'hE7, ack);                chk("R3 no data ack", ack, 1'b0);
            m_stop();
        end
        m_start();
        m_wbyte(8'hDD ^ 8'h40, ack);            chk("R3 no read ack", ack, 1'b0);
        m_rbyte(1'b0, d);                        chk("R3 bus idle on read", d, 8'hFF);
        m_stop();
        verify_all("R3 bank unchanged");

        // R6: fixed pointer mode
        xfer_write(4'hA, 1, 8'h01, 8'h00);
        chk("R6 mode write stepped once", mptr, 4'hB);
        xfer_write(4'h5, 3, 8'h11, 8'h11);
        chk("R6 pointer held", mptr, 4'h5);
        set_ptr(4'h5);
        xfer_read(3, "R6 repeated read same register");
        xfer_write(4'hA, 1, 8'h00, 8'h00);
        chk("R6 clear mode pointer held", mptr, 4'hA);
        verify_all("R6 bank after fixed mode");

        // R9: repeated START after a pointer-only write, then R7 persistence
        m_start();
        m_wbyte(8'hDC, ack);   chk("R9 address ack", ack, 1'b1);
        m_wbyte(8'h07, ack);   chk("R9 pointer ack", ack, 1'b1);
        mptr = 4'h7;
        m_start();
        m_wbyte(8'hDD, ack);   chk("R9 read after repeated start", ack, 1'b1);
        m_rbyte(1'b1, d);      chk("R9 first byte", d, mdl[7]);
        m_rbyte(1'b0, d);      chk("R9 second byte", d, mdl[8]);
        m_stop();
        mptr = 4'h9;
        xfer_read(1, "R7 pointer persists across transfers");

        // R8: NACK ends transmission; extra clocks see a released bus
        m_start();
        m_wbyte(8'hDD, ack);   chk("R8 address ack", ack, 1'b1);
        m_rbyte(1'b0, d);      chk("R8 byte before nack", d, mdl[mptr]);
        mptr = adv(mptr);
        m_rbyte(1'b0, d);      chk("R8 released after nack", d, 8'hFF);
        m_stop();
        xfer_read(1, "R8 pointer unchanged by extra clocks");

        // R9: START in mid-byte discards the partial write
        m_start();
        m_wbyte(8'hDC, ack);   chk("R9 abort address ack", ack, 1'b1);
        m_wbyte(8'h04, ack);   chk("R9 abort pointer ack", ack, 1'b1);
        mptr = 4'h4;
        m_bits(8'hA0, 3);
        m_start();
        m_wbyte(8'hDD, ack);   chk("R9 restart address ack", ack, 1'b1);
        m_rbyte(1'b0, d);      chk("R9 partial byte not stored", d, mdl[4]);
        m_stop();
        chk("R10 sda released at end", sda_oe, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule